// File: doc/BRIEF.md
# Montgomery Coefficient Unit

This unit computes the coefficient used by word-serial Montgomery multipliers: the value R with N·R + 1 ≡ 0 modulo 2^(L·W), where N is an odd modulus of L words of W bits. The modulus is fetched word by word from an operand memory through a read port, and the L result words are written out through a write port. Software or a surrounding controller pulses `start` while `ready` is high, and the run ends when `ready` returns.

R starts at 1. For each bit position k from 1 to L·W − 1, the unit forms the low L words of R times the negated modulus, one word product per cycle. It reads bit k of that truncated product, and if the bit is set, R gains 2^k. The candidate R + 2^k is built in the same pass as the first product row. That pass also shifts a one-hot power vector left by one bit and takes a copy of the current R. A single word adder, a single word multiply-accumulate element and a single-bit shifter serve the whole word loop. The adder also negates the modulus while it loads. No check is made that the modulus is odd.

Top module: `mont_coeff_unit`

## Requirements
- R1: After reset, `ready` is 1, and `opd_rd` and `res_we` are 0. Neither strobe is ever high while `ready` is high.
- R2: A `start` pulse sampled while `ready` is 1 begins a run, and `len_words` is captured at that edge. `ready` is 0 from the next cycle until the cycle after the last result write.
- R3: A run issues exactly `len_words` operand reads, at word addresses 0, 1, … in consecutive cycles. `opd_rdata` is taken one cycle after each read strobe.
- R4: The result is written as `len_words` words in consecutive cycles at word addresses 0 upward, least significant word first. `ready` rises in the cycle after the last write.
- R5: For an odd modulus N of L words, the written result R satisfies (N·R + 1) mod 2^(32·L) = 0.
- R6: The length is set at run time for each run, from 1 to MAX_WORDS. No word address at or above the length is read or written.
- R7: A `start` pulse while `ready` is 0 has no effect. The run in progress keeps `ready` low and still writes the correct result.
- R8: The number of cycles from the start edge to the first result write is fixed. It is (L + 2) + (32·L − 1)·(L·(L+1)/2 + 1), counted in clock periods from the start-sampling edge to the period in which `res_we` is first high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (honoured only while ready) |
| len_words | input | LEN_W | Operand length in words, 1..MAX_WORDS |
| ready | output | 1 | Idle and able to accept start |
| opd_rd | output | 1 | Operand memory read strobe |
| opd_addr | output | ADDR_W | Operand word address |
| opd_rdata | input | WORD_W | Operand word, valid one cycle after opd_rd |
| res_we | output | 1 | Result write strobe |
| res_addr | output | ADDR_W | Result word address |
| res_wdata | output | WORD_W | Result word |

## Verification
The unit's accumulated state only becomes visible when the coefficient is written out. A single wrong carry, a wrong update flag or a misplaced product word in any of the L·W − 1 rounds therefore shows up only at the end of the run, as a result that fails the N·R + 1 identity. Faults in sequencing show sooner. A wrong row bound or a wrong iteration limit shifts the first write away from its fixed cycle count. Faults in the address counters show at once on the read and write strobes.

// File: rtl/mci_pkg.sv
package mci_pkg;
  typedef enum logic [2:0] {
    MCI_IDLE,
    MCI_LOAD,
    MCI_MAC,
    MCI_UPD,
    MCI_WRITE
  } mci_state_e;

  // Word add with carry: returns {carry, sum}.
  function automatic logic [32:0] mci_add32(input logic [31:0] a, input logic [31:0] b,
                                            input logic ci);
    return {1'b0, a} + {1'b0, b} + {32'd0, ci};
  endfunction
endpackage

// File: rtl/mci_word_adder.sv
module mci_word_adder #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              ci,
  output logic [WORD_W-1:0] sum,
  output logic              co
);
  logic [WORD_W:0] full;
  assign full = {1'b0, a} + {1'b0, b} + {{WORD_W{1'b0}}, ci};
  assign sum  = full[WORD_W-1:0];
  assign co   = full[WORD_W];
endmodule

// File: rtl/mci_word_mac.sv
module mci_word_mac #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] ci,
  output logic [WORD_W-1:0] lo,
  output logic [WORD_W-1:0] hi
);
  localparam int DW = 2 * WORD_W;
  logic [DW-1:0] prod;
  assign prod = (DW'(a) * DW'(b)) + DW'(acc) + DW'(ci);
  assign lo   = prod[WORD_W-1:0];
  assign hi   = prod[DW-1:WORD_W];
endmodule

// File: rtl/mci_bit_shift.sv
module mci_bit_shift #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] din,
  input  logic              ci,
  output logic [WORD_W-1:0] dout,
  output logic              co
);
  assign dout = {din[WORD_W-2:0], ci};
  assign co   = din[WORD_W-1];
endmodule

// File: rtl/mont_coeff_unit.sv
module mont_coeff_unit
  import mci_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MAX_WORDS = 8,
  localparam int ADDR_W   = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int LEN_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_words,
  output logic              ready,
  output logic              opd_rd,
  output logic [ADDR_W-1:0] opd_addr,
  input  logic [WORD_W-1:0] opd_rdata,
  output logic              res_we,
  output logic [ADDR_W-1:0] res_addr,
  output logic [WORD_W-1:0] res_wdata
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int K_W   = $clog2(MAX_WORDS * WORD_W + 1);
  localparam int WI_W  = K_W - BIT_W;

  mci_state_e state_q;
  logic [WORD_W-1:0] nn_q [MAX_WORDS];
  logic [WORD_W-1:0] r_q  [MAX_WORDS];
  logic [WORD_W-1:0] b_q  [MAX_WORDS];
  logic [WORD_W-1:0] rb_q [MAX_WORDS];
  logic [WORD_W-1:0] rr_q [MAX_WORDS];
  logic [WORD_W-1:0] t_q  [MAX_WORDS];

  logic [LEN_W-1:0]  len_q, cnt_q;
  logic              rd_vld_q;
  logic [ADDR_W-1:0] rd_idx_q, i_q, j_q;
  logic [K_W-1:0]    k_q;
  logic              add_c_q, sh_c_q, flag_q;
  logic [WORD_W-1:0] mac_c_q;

  // Named internal events
  logic              load_fire, mac_fire, row0_fire, row_end, last_row, upd_fire;
  logic              flag_tap, k_last, load_last;
  logic [ADDR_W-1:0] tij;
  logic [BIT_W-1:0]  bit_idx;

  assign tij       = i_q + j_q;
  assign bit_idx   = k_q[BIT_W-1:0];
  assign load_fire = (state_q == MCI_LOAD) && rd_vld_q;
  assign load_last = load_fire && (LEN_W'(rd_idx_q) == len_q - LEN_W'(1));
  assign mac_fire  = (state_q == MCI_MAC);
  assign row0_fire = mac_fire && (i_q == '0);
  assign row_end   = LEN_W'(j_q) == len_q - LEN_W'(1) - LEN_W'(i_q);
  assign last_row  = LEN_W'(i_q) == len_q - LEN_W'(1);
  assign upd_fire  = (state_q == MCI_UPD);
  assign flag_tap  = mac_fire && (WI_W'(tij) == k_q[K_W-1:BIT_W]);
  assign k_last    = k_q == ((K_W'(len_q) << BIT_W) - K_W'(1));

  // Shared arithmetic elements
  logic [WORD_W-1:0] add_a, add_b, add_sum, sh_out, mac_lo, mac_hi, mac_ci;
  logic              add_ci, add_co, sh_ci, sh_co;

  always_comb begin
    if (state_q == MCI_LOAD) begin
      add_a  = ~opd_rdata;
      add_b  = {{(WORD_W-1){1'b0}}, (rd_idx_q == '0)};
      add_ci = (rd_idx_q == '0) ? 1'b0 : add_c_q;
    end else begin
      add_a  = r_q[j_q];
      add_b  = sh_out;
      add_ci = (j_q == '0) ? 1'b0 : add_c_q;
    end
    sh_ci  = (j_q == '0) ? 1'b0 : sh_c_q;
    mac_ci = (j_q == '0) ? '0 : mac_c_q;
  end

  mci_word_adder #(.WORD_W(WORD_W)) u_add (
    .a(add_a), .b(add_b), .ci(add_ci), .sum(add_sum), .co(add_co)
  );

  mci_bit_shift #(.WORD_W(WORD_W)) u_shf (
    .din(b_q[j_q]), .ci(sh_ci), .dout(sh_out), .co(sh_co)
  );

  mci_word_mac #(.WORD_W(WORD_W)) u_mac (
    .a(r_q[j_q]), .b(nn_q[i_q]), .acc(t_q[tij]), .ci(mac_ci), .lo(mac_lo), .hi(mac_hi)
  );

  // Ports
  assign ready     = (state_q == MCI_IDLE);
  assign opd_rd    = (state_q == MCI_LOAD) && (cnt_q < len_q);
  assign opd_addr  = cnt_q[ADDR_W-1:0];
  assign res_we    = (state_q == MCI_WRITE);
  assign res_addr  = cnt_q[ADDR_W-1:0];
  assign res_wdata = r_q[cnt_q[ADDR_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= MCI_IDLE;
      len_q    <= '0;
      cnt_q    <= '0;
      rd_vld_q <= 1'b0;
      rd_idx_q <= '0;
      i_q      <= '0;
      j_q      <= '0;
      k_q      <= '0;
      add_c_q  <= 1'b0;
      sh_c_q   <= 1'b0;
      flag_q   <= 1'b0;
      mac_c_q  <= '0;
      for (int w = 0; w < MAX_WORDS; w++) begin
        nn_q[w] <= '0;
        r_q[w]  <= '0;
        b_q[w]  <= '0;
        rb_q[w] <= '0;
        rr_q[w] <= '0;
        t_q[w]  <= '0;
      end
    end else begin
      case (state_q)
        MCI_IDLE: begin
          if (start) begin
            len_q    <= len_words;
            cnt_q    <= '0;
            rd_vld_q <= 1'b0;
            state_q  <= MCI_LOAD;
          end
        end
        MCI_LOAD: begin
          rd_vld_q <= opd_rd;
          rd_idx_q <= cnt_q[ADDR_W-1:0];
          if (opd_rd) cnt_q <= cnt_q + LEN_W'(1);
          if (load_fire) begin
            nn_q[rd_idx_q] <= add_sum;
            add_c_q        <= add_co;
          end
          if (load_last) begin
            state_q <= MCI_MAC;
            i_q     <= '0;
            j_q     <= '0;
            k_q     <= K_W'(1);
            for (int w = 0; w < MAX_WORDS; w++) begin
              r_q[w] <= (w == 0) ? WORD_W'(1) : '0;
              b_q[w] <= (w == 0) ? WORD_W'(1) : '0;
              t_q[w] <= '0;
            end
          end
        end
        MCI_MAC: begin
          t_q[tij] <= mac_lo;
          mac_c_q  <= mac_hi;
          if (flag_tap) flag_q <= mac_lo[bit_idx];
          if (row0_fire) begin
            b_q[j_q]  <= sh_out;
            sh_c_q    <= sh_co;
            rb_q[j_q] <= add_sum;
            add_c_q   <= add_co;
            rr_q[j_q] <= r_q[j_q];
          end
          if (row_end) begin
            j_q <= '0;
            if (last_row) begin
              i_q     <= '0;
              state_q <= MCI_UPD;
            end else begin
              i_q <= i_q + ADDR_W'(1);
            end
          end else begin
            j_q <= j_q + ADDR_W'(1);
          end
        end
        MCI_UPD: begin
          for (int w = 0; w < MAX_WORDS; w++) begin
            r_q[w] <= flag_q ? rb_q[w] : rr_q[w];
            t_q[w] <= '0;
          end
          if (k_last) begin
            cnt_q   <= '0;
            state_q <= MCI_WRITE;
          end else begin
            k_q     <= k_q + K_W'(1);
            state_q <= MCI_MAC;
          end
        end
        MCI_WRITE: begin
          cnt_q <= cnt_q + LEN_W'(1);
          if (cnt_q == len_q - LEN_W'(1)) state_q <= MCI_IDLE;
        end
        default: state_q <= MCI_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mci_checker.sv
module mci_checker #(
  parameter int ADDR_W = 3,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ready,
  input logic              opd_rd,
  input logic [ADDR_W-1:0] opd_addr,
  input logic              res_we,
  input logic [ADDR_W-1:0] res_addr,
  input logic [LEN_W-1:0]  len_q,
  input logic              mac_fire,
  input logic [ADDR_W-1:0] i_q,
  input logic [ADDR_W-1:0] j_q
);
  a_r1_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!opd_rd && !res_we));

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);

  a_r3_read_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    opd_rd |-> (LEN_W'(opd_addr) < len_q));

  a_r3_read_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (opd_rd && $past(opd_rd)) |-> (opd_addr == ADDR_W'($past(opd_addr) + ADDR_W'(1))));

  a_r4_write_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_we) |-> (res_addr == '0));

  a_r4_write_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && $past(res_we)) |-> (res_addr == ADDR_W'($past(res_addr) + ADDR_W'(1))));

  a_r4_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && (LEN_W'(res_addr) == len_q - LEN_W'(1))) |=> ready);

  a_r6_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (LEN_W'(res_addr) < len_q));

  a_r6_product_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mac_fire |-> ((LEN_W'(i_q) + LEN_W'(j_q)) < len_q));
endmodule

bind mont_coeff_unit mci_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
  .opd_rd(opd_rd), .opd_addr(opd_addr), .res_we(res_we), .res_addr(res_addr),
  .len_q(len_q), .mac_fire(mac_fire), .i_q(i_q), .j_q(j_q)
);

// File: tb/mont_coeff_unit_bench.sv
module mont_coeff_unit_bench;
  localparam int W    = 32;
  localparam int MAXW = 8;
  localparam int AW   = 3;
  localparam int LW   = 4;
  localparam int BITS = MAXW * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] len_words = '0;
  logic          ready, opd_rd, res_we;
  logic [AW-1:0] opd_addr, res_addr;
  logic [W-1:0]  opd_rdata = '0;
  logic [W-1:0]  res_wdata;

  always #10 clk = ~clk;  // 50 MHz

  mont_coeff_unit #(.WORD_W(W), .MAX_WORDS(MAXW)) u_mont_coeff_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .len_words(len_words), .ready(ready),
    .opd_rd(opd_rd), .opd_addr(opd_addr), .opd_rdata(opd_rdata),
    .res_we(res_we), .res_addr(res_addr), .res_wdata(res_wdata)
  );

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  logic [W-1:0] mem [MAXW];
  logic [W-1:0] cap [MAXW];
  logic [W-1:0] exp_w [$];
  int           exp_a [$];
  int           n_reads = 0;
  int           n_writes = 0;
  int           next_rd = 0;

  task automatic check(input string req, input bit ok, input logic [BITS-1:0] act,
                       input logic [BITS-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Operand memory model, one cycle read latency
  always @(posedge clk) if (opd_rd) opd_rdata <= mem[opd_addr];

  // Read monitor (R3, R6)
  always @(negedge clk) if (rst_n && opd_rd) begin
    check("R3 read order", int'(opd_addr) == next_rd, opd_addr, next_rd);
    next_rd++;
    n_reads++;
  end

  // Result monitor: scoreboard pop and compare (R4, R5)
  always @(negedge clk) if (rst_n && res_we) begin
    if (exp_w.size() == 0) begin
      check("R4 unexpected write", 1'b0, res_addr, 0);
    end else begin
      automatic logic [W-1:0] ew = exp_w.pop_front();
      automatic int ea = exp_a.pop_front();
      check("R4 write address", int'(res_addr) == ea, res_addr, ea);
      check("R5 result word", res_wdata == ew, res_wdata, ew);
      cap[res_addr] = res_wdata;
    end
    n_writes++;
  end

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        check("watchdog", 1'b0, cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic run_case(input int len, input logic [BITS-1:0] n_in, input bit poke);
    logic [BITS-1:0] mask, n, x, expv, got, prod;
    int cyc, expect_cyc, m;
    mask = (len == MAXW) ? {BITS{1'b1}} : ((BITS'(1) << (W * len)) - BITS'(1));
    n = n_in & mask;
    n[0] = 1'b1;
    for (int w = 0; w < MAXW; w++) begin
      mem[w] = (w < len) ? n[w*W +: W] : 32'hDEAD_BEEF;
      cap[w] = '0;
    end
    // Independent reference: Newton iteration for the inverse, then negate
    x = BITS'(1);
    for (int it = 0; it < 9; it++) x = (x * (BITS'(2) - n * x)) & mask;
    expv = (BITS'(0) - x) & mask;
    for (int w = 0; w < len; w++) begin
      exp_w.push_back(expv[w*W +: W]);
      exp_a.push_back(w);
    end
    n_reads = 0; n_writes = 0; next_rd = 0;

    while (!ready) @(negedge clk);
    start = 1'b1;
    len_words = LW'(len);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check("R2 ready drops", ready == 1'b0, ready, 0);
    while (!res_we) begin
      if (poke && cyc == 20) begin
        start = 1'b1;
        len_words = LW'(1);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (poke && cyc == 21) check("R7 start ignored while busy", ready == 1'b0, ready, 0);
    end
    start = 1'b0;
    m = len * (len + 1) / 2;
    expect_cyc = (len + 2) + (W * len - 1) * (m + 1);
    check("R8 latency", cyc == expect_cyc, cyc, expect_cyc);
    while (!ready) @(negedge clk);
    check("R3 read count", n_reads == len, n_reads, len);
    check("R6 write count", n_writes == len, n_writes, len);
    check("R4 scoreboard empty", exp_w.size() == 0, exp_w.size(), 0);
    got = '0;
    for (int w = 0; w < len; w++) got[w*W +: W] = cap[w];
    prod = (n * got + BITS'(1)) & mask;
    check("R5 identity", prod == '0, prod, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready after reset", ready == 1'b1, ready, 1);
    check("R1 no strobes in reset", !opd_rd && !res_we, {opd_rd, res_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", ready && !opd_rd && !res_we, {ready, opd_rd, res_we}, 3'b100);

    run_case(1, BITS'({$urandom, $urandom}), 1'b0);          // R6 minimum length
    run_case(2, BITS'({$urandom, $urandom, $urandom}), 1'b0);
    run_case(4, {8{$urandom}}, 1'b0);
    run_case(4, {$urandom, $urandom, $urandom, $urandom,
                 $urandom, $urandom, $urandom, $urandom}, 1'b0);
    run_case(4, BITS'(1), 1'b0);                              // N = 1
    run_case(3, {BITS{1'b1}}, 1'b0);                          // N = all ones
    run_case(3, {$urandom, $urandom, $urandom, $urandom,
                 $urandom, $urandom, $urandom, $urandom}, 1'b1); // R7
    run_case(MAXW, {$urandom, $urandom, $urandom, $urandom,
                    $urandom, $urandom, $urandom, $urandom}, 1'b0); // R6 maximum

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule